// File: doc/BRIEF.md
# Key-Locked Control Register Bank

This block holds a bank of 32-bit system control words behind a one-cycle register bus. Most of the bank is guarded by a key register: software must write a fixed magic word into the key slot before the guarded words accept writes. A short list of words never accepts writes. The words only store values and have no side effects.

At every synchronous reset the bank loads one of two reset images. A revision input picks the image. After the image is loaded, four words are overwritten from inputs: the key slot, two strap words and the revision word. An access that falls outside the bank, is misaligned, hits a guarded word while locked, writes a read-only word or reads the write-only word raises a one-cycle error pulse together with the ready response.

Top module: `ctl_regbank`

## Requirements
- R1: The word index is `bus_addr[11:2]`. An access with `bus_addr[1:0]` not equal to zero is ignored, returns read data 0 and raises the error flag.
- R2: A write to byte offset 0x000 (the key slot) stores 1 when the data equals `KEY_MAGIC` (default 0x1688A8A8) and 0 for any other data. The key slot is always writable and raises no error.
- R3: While the key slot holds zero, writes to offsets 0x004 through 0x100 are discarded and flagged. Offsets 0x104 and above stay writable and raise no error.
- R4: Writes to offsets 0x014, 0x050 to 0x06C, 0x078, 0x07C, 0x0E0 and 0x0E4 are discarded and flagged. These words keep their reset values.
- R5: An access whose index is 106 or higher (offset 0x1A8 up to 0xFFC) is ignored, returns read data 0 and raises the error flag.
- R6: A read of offset 0x0C0 raises the error flag but still returns the stored word.
- R7: At reset, revision codes `REV_B0` (default 0x00020000) and `REV_B1` (default 0x00020001) select the second image. Any other code selects the first image. The images differ at 0x024 (0x00000291 in the first, 0x93000400 in the second), 0x088 (0x01000000 / 0x03000000), 0x08C (0x000000FF / 0x00000000) and 0x09C (0x003FFFF3 / 0x023FFFF3).
- R8: Both images hold, among others, 0x004 = 0xFFCFFEDC, 0x008 = 0xF3F40000, 0x040 = 0x000000C0, 0x0E4 = 0x000000FF and 0x1A4 = 0x00002402. Words that neither image lists reset to zero.
- R9: After the image is loaded at reset, 0x000 takes `key_init`, 0x070 takes `strap_a`, 0x0D0 takes `strap_b` and 0x07C takes `rev_code`. A nonzero `key_init` leaves the bank unlocked.
- R10: `bus_ready` is high in the cycle after each cycle with `bus_sel` high, and low otherwise. Read data appears in that same cycle. `bus_rdata` is 0 after writes and when idle. All three outputs are 0 after reset.
- R11: `bus_err` is high only together with `bus_ready`, and only for the one cycle that answers a faulty access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; reloads the bank |
| rev_code | input | 32 | Revision code; selects the reset image and is copied to 0x07C |
| strap_a | input | 32 | Reset value for offset 0x070 |
| strap_b | input | 32 | Reset value for offset 0x0D0 |
| key_init | input | 32 | Reset value for the key slot |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Response strobe, one cycle after bus_sel |
| bus_err | output | 1 | Error pulse for a faulty access |

## Verification
The bench first writes a guarded word while the bank is locked, then unlocks it, then locks it again. A lock check with the wrong polarity or a wrong window boundary would either let the write at 0x040 through or reject the write at 0x104. A wrong key value is written before the magic word, so a design that stores the raw data, or stores the flag without comparing, reads back something other than 0 and 1. Read-only words are written and read back, and so are words beyond the bank and misaligned words; a design that lets them through would show a changed word, nonzero read data or a missing error. Resets with each kind of revision code check the four differing image words and the strap, revision and key overrides. A design whose override order was reversed, or whose image select was wrong, would read back the wrong word.

// File: rtl/scb_pkg.sv
package scb_pkg;

    localparam int WORD_W = 32;

    // Slots whose position the access rules depend on (word indices).
    localparam int KEY_IDX       = 0;
    localparam int GUARD_END_IDX = 65;   // first index outside the locked window
    localparam int STRAP_A_IDX   = 28;
    localparam int REV_IDX       = 31;
    localparam int STRAP_B_IDX   = 52;
    localparam int WO_IDX        = 48;

    typedef enum logic {
        TBL_FIRST  = 1'b0,
        TBL_SECOND = 1'b1
    } tbl_e;

    typedef struct packed {
        logic oob;
        logic locked_hit;
        logic ro_hit;
        logic wo_read;
    } acc_flags_t;

    function automatic logic is_read_only(int idx);
        return (idx == 5) || (idx >= 20 && idx <= 27) || (idx == 30) ||
               (idx == 31) || (idx == 56) || (idx == 57);
    endfunction

    function automatic logic is_guarded(int idx);
        return (idx > KEY_IDX) && (idx < GUARD_END_IDX);
    endfunction

    // Reset image contents per word index.
    function automatic logic [WORD_W-1:0] image_word(tbl_e t, int idx);
        logic [WORD_W-1:0] v;
        v = '0;
        case (idx)
            1:   v = 32'hFFCF_FEDC;
            2:   v = 32'hF3F4_0000;
            3:   v = 32'h19FC_3E8B;
            7:   v = 32'h0002_6108;
            8:   v = 32'h0003_0291;
            9:   v = (t == TBL_SECOND) ? 32'h9300_0400 : 32'h0000_0291;
            11:  v = 32'h0000_0010;
            12:  v = 32'h2000_1A03;
            13:  v = 32'h2000_1A03;
            14:  v = 32'h0400_0030;
            15:  v = 32'h0000_0001;
            16:  v = 32'h0000_00C0;
            19:  v = 32'h0000_0023;
            29:  v = 32'h0000_000E;
            33:  v = 32'h0000_F000;
            34:  v = (t == TBL_SECOND) ? 32'h0300_0000 : 32'h0100_0000;
            35:  v = (t == TBL_SECOND) ? 32'h0000_0000 : 32'h0000_00FF;
            36:  v = 32'h0000_A000;
            39:  v = (t == TBL_SECOND) ? 32'h023F_FFF3 : 32'h003F_FFF3;
            41:  v = 32'hFFFF_0000;
            42:  v = 32'h000F_FFFF;
            56:  v = 32'h0000_00FF;
            57:  v = 32'h0000_00FF;
            65:  v = 32'h8000_0000;
            68:  v = 32'h1E60_0000;
            69:  v = 32'hC000_0000;
            88:  v = 32'h0000_1903;
            96:  v = 32'h0000_007B;
            105: v = 32'h0000_2402;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/scb_rev_select.sv
module scb_rev_select
    import scb_pkg::*;
#(
    parameter logic [WORD_W-1:0] REV_A0 = 32'h0001_0000,
    parameter logic [WORD_W-1:0] REV_A1 = 32'h0001_0001,
    parameter logic [WORD_W-1:0] REV_B0 = 32'h0002_0000,
    parameter logic [WORD_W-1:0] REV_B1 = 32'h0002_0001
) (
    input  logic [WORD_W-1:0] rev_code,
    output tbl_e              tbl
);
    logic hit_a;
    logic hit_b;

    always_comb begin
        hit_a = (rev_code == REV_A0) || (rev_code == REV_A1);
        hit_b = (rev_code == REV_B0) || (rev_code == REV_B1);
        // Codes of the first group and unknown codes share the first image.
        if (hit_b && !hit_a) tbl = TBL_SECOND;
        else                 tbl = TBL_FIRST;
    end
endmodule

// File: rtl/scb_access_decode.sv
module scb_access_decode
    import scb_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_REGS  = 106,
    parameter int                IDX_W     = 7,
    parameter logic [WORD_W-1:0] KEY_MAGIC = 32'h1688_A8A8
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] key_q,
    output logic              wr_en,
    output logic [IDX_W-1:0]  idx,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_ok,
    output logic              err
);
    localparam int RAW_W = ADDR_W - 2;

    logic [RAW_W-1:0] raw;
    acc_flags_t       flags;
    logic             locked;

    assign raw    = addr[ADDR_W-1:2];
    assign idx    = raw[IDX_W-1:0];
    assign locked = (key_q == '0);

    always_comb begin
        int idx_i;
        idx_i            = int'(raw);
        flags.oob        = (addr[1:0] != 2'b00) || (idx_i >= NUM_REGS);
        flags.locked_hit = wr && locked && is_guarded(idx_i);
        flags.ro_hit     = wr && is_read_only(idx_i);
        flags.wo_read    = !wr && (idx_i == WO_IDX);
        wr_en   = sel && wr && !flags.oob && !flags.locked_hit && !flags.ro_hit;
        rd_ok   = sel && !wr && !flags.oob;
        err     = sel && (|flags);
        wr_data = (idx_i == KEY_IDX) ? {{(WORD_W-1){1'b0}}, (wdata == KEY_MAGIC)}
                                     : wdata;
    end
endmodule

// File: rtl/scb_reg_store.sv
module scb_reg_store
    import scb_pkg::*;
#(
    parameter int NUM_REGS = 106,
    parameter int IDX_W    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  tbl_e              tbl,
    input  logic [WORD_W-1:0] rev_code,
    input  logic [WORD_W-1:0] strap_a,
    input  logic [WORD_W-1:0] strap_b,
    input  logic [WORD_W-1:0] key_init,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] key_q
);
    logic [WORD_W-1:0] mem_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        localparam logic RO = is_read_only(g);
        logic [WORD_W-1:0] r_q;
        logic [WORD_W-1:0] rst_val;

        // Inputs override the image for the key, strap and revision slots.
        if (g == KEY_IDX) begin : g_key
            assign rst_val = key_init;
        end else if (g == STRAP_A_IDX) begin : g_sa
            assign rst_val = strap_a;
        end else if (g == STRAP_B_IDX) begin : g_sb
            assign rst_val = strap_b;
        end else if (g == REV_IDX) begin : g_rev
            assign rst_val = rev_code;
        end else begin : g_img
            assign rst_val = image_word(tbl, g);
        end

        if (RO) begin : g_ro
            always_ff @(posedge clk) begin
                if (rst) r_q <= rst_val;
            end
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)                                     r_q <= rst_val;
                else if (wr_en && (wr_idx == IDX_W'(g)))     r_q <= wr_data;
            end
        end

        assign mem_q[g] = r_q;
    end

    assign rd_word = mem_q[rd_idx];
    assign key_q   = mem_q[KEY_IDX];

    AST_KEY_IS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_idx == IDX_W'(KEY_IDX))) |=> (key_q[WORD_W-1:1] == '0)) // R2
        else $error("key slot holds more than a flag after a key write");
endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import scb_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_REGS  = 106,
    parameter logic [WORD_W-1:0] KEY_MAGIC = 32'h1688_A8A8,
    parameter logic [WORD_W-1:0] REV_A0    = 32'h0001_0000,
    parameter logic [WORD_W-1:0] REV_A1    = 32'h0001_0001,
    parameter logic [WORD_W-1:0] REV_B0    = 32'h0002_0000,
    parameter logic [WORD_W-1:0] REV_B1    = 32'h0002_0001
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       rev_code,
    input  logic [31:0]       strap_a,
    input  logic [31:0]       strap_b,
    input  logic [31:0]       key_init,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_ready,
    output logic              bus_err
);
    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int RAW_W = ADDR_W - 2;

    tbl_e              tbl_sel;
    logic              acc_we;
    logic              acc_rd_ok;
    logic              acc_err;
    logic [IDX_W-1:0]  acc_idx;
    logic [WORD_W-1:0] acc_wdata;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] key_q;
    logic [RAW_W-1:0]  raw;

    assign raw = bus_addr[ADDR_W-1:2];

    scb_rev_select #(
        .REV_A0(REV_A0), .REV_A1(REV_A1), .REV_B0(REV_B0), .REV_B1(REV_B1)
    ) u_rev (
        .rev_code (rev_code),
        .tbl      (tbl_sel)
    );

    scb_access_decode #(
        .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .KEY_MAGIC(KEY_MAGIC)
    ) u_dec (
        .sel     (bus_sel),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .key_q   (key_q),
        .wr_en   (acc_we),
        .idx     (acc_idx),
        .wr_data (acc_wdata),
        .rd_ok   (acc_rd_ok),
        .err     (acc_err)
    );

    scb_reg_store #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .tbl      (tbl_sel),
        .rev_code (rev_code),
        .strap_a  (strap_a),
        .strap_b  (strap_b),
        .key_init (key_init),
        .wr_en    (acc_we),
        .wr_idx   (acc_idx),
        .wr_data  (acc_wdata),
        .rd_idx   (acc_idx),
        .rd_word  (rd_word),
        .key_q    (key_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_ready <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_sel;
            bus_err   <= acc_err;
            bus_rdata <= acc_rd_ok ? rd_word : '0;
        end
    end

    AST_READY_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
        bus_sel |=> bus_ready) // R10
        else $error("no ready after an access");

    AST_NO_SPURIOUS_READY: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !bus_ready) // R10
        else $error("ready without an access");

    AST_ERR_WITH_READY: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> bus_ready) // R11
        else $error("error flag without ready");

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && (int'(raw) >= NUM_REGS)) |=> (bus_rdata == '0)) // R5
        else $error("out-of-range read returned data");

    AST_LOCKED_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (acc_we && (raw != '0) && (int'(raw) < GUARD_END_IDX)) |-> (key_q != '0)) // R3
        else $error("guarded word written while locked");
endmodule

// File: tb/ctl_regbank_tb.sv
`timescale 1ns/1ps
module ctl_regbank_tb;

    localparam logic [31:0] MAGIC  = 32'h1688_A8A8;
    localparam logic [31:0] REV_A1 = 32'h0001_0001;
    localparam logic [31:0] REV_B0 = 32'h0002_0000;
    localparam logic [31:0] REV_B1 = 32'h0002_0001;
    localparam logic [31:0] SA     = 32'h1111_2222;
    localparam logic [31:0] SB     = 32'h3333_4444;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_data;
        logic        exp_err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 37;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 32'h0,         32'h0,         1'b0, 4'd9},  // R9 key_init
        '{1'b0, 12'h024, 32'h0,         32'h0000_0291, 1'b0, 4'd7},  // R7 first image
        '{1'b0, 12'h004, 32'h0,         32'hFFCF_FEDC, 1'b0, 4'd8},  // R8
        '{1'b0, 12'h070, 32'h0,         SA,            1'b0, 4'd9},  // R9 strap_a
        '{1'b0, 12'h0D0, 32'h0,         SB,            1'b0, 4'd9},  // R9 strap_b
        '{1'b0, 12'h07C, 32'h0,         REV_A1,        1'b0, 4'd9},  // R9 revision
        '{1'b1, 12'h040, 32'hDEAD_BEEF, 32'h0,         1'b1, 4'd3},  // R3 locked write
        '{1'b0, 12'h040, 32'h0,         32'h0000_00C0, 1'b0, 4'd3},  // R3 unchanged
        '{1'b1, 12'h104, 32'hCAFE_F00D, 32'h0,         1'b0, 4'd3},  // R3 outside window
        '{1'b0, 12'h104, 32'h0,         32'hCAFE_F00D, 1'b0, 4'd3},  // R3
        '{1'b1, 12'h000, 32'h1234_5678, 32'h0,         1'b0, 4'd2},  // R2 wrong key
        '{1'b0, 12'h000, 32'h0,         32'h0,         1'b0, 4'd2},  // R2
        '{1'b1, 12'h000, MAGIC,         32'h0,         1'b0, 4'd2},  // R2 magic
        '{1'b0, 12'h000, 32'h0,         32'h1,         1'b0, 4'd2},  // R2
        '{1'b1, 12'h040, 32'hDEAD_BEEF, 32'h0,         1'b0, 4'd3},  // R3 unlocked
        '{1'b0, 12'h040, 32'h0,         32'hDEAD_BEEF, 1'b0, 4'd3},  // R3
        '{1'b1, 12'h014, 32'h55,        32'h0,         1'b1, 4'd4},  // R4
        '{1'b0, 12'h014, 32'h0,         32'h0,         1'b0, 4'd4},  // R4
        '{1'b1, 12'h05C, 32'h77,        32'h0,         1'b1, 4'd4},  // R4
        '{1'b0, 12'h05C, 32'h0,         32'h0,         1'b0, 4'd4},  // R4
        '{1'b1, 12'h0E4, 32'h1,         32'h0,         1'b1, 4'd4},  // R4
        '{1'b0, 12'h0E4, 32'h0,         32'h0000_00FF, 1'b0, 4'd4},  // R4
        '{1'b1, 12'h07C, 32'h0,         32'h0,         1'b1, 4'd4},  // R4
        '{1'b0, 12'h07C, 32'h0,         REV_A1,        1'b0, 4'd4},  // R4
        '{1'b0, 12'h1A8, 32'h0,         32'h0,         1'b1, 4'd5},  // R5
        '{1'b1, 12'h1A8, 32'h1,         32'h0,         1'b1, 4'd5},  // R5
        '{1'b0, 12'hFFC, 32'h0,         32'h0,         1'b1, 4'd5},  // R5
        '{1'b1, 12'h0C0, 32'hABCD,      32'h0,         1'b0, 4'd6},  // R6
        '{1'b0, 12'h0C0, 32'h0,         32'hABCD,      1'b1, 4'd6},  // R6
        '{1'b1, 12'h042, 32'h1,         32'h0,         1'b1, 4'd1},  // R1 misaligned
        '{1'b0, 12'h041, 32'h0,         32'h0,         1'b1, 4'd1},  // R1
        '{1'b0, 12'h040, 32'h0,         32'hDEAD_BEEF, 1'b0, 4'd1},  // R1 untouched
        '{1'b0, 12'h1A4, 32'h0,         32'h0000_2402, 1'b0, 4'd8},  // R8 last word
        '{1'b1, 12'h000, 32'h0,         32'h0,         1'b0, 4'd2},  // R2 relock
        '{1'b1, 12'h008, 32'h1,         32'h0,         1'b1, 4'd3},  // R3
        '{1'b0, 12'h008, 32'h0,         32'hF3F4_0000, 1'b0, 4'd3},  // R3
        '{1'b0, 12'h0C8, 32'h0,         32'h0,         1'b0, 4'd8}   // R8 unlisted zero
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rev_code = REV_A1;
    logic [31:0] strap_a  = SA;
    logic [31:0] strap_b  = SB;
    logic [31:0] key_init = 32'h0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        bus_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    ctl_regbank u_dut (
        .clk(clk), .rst(rst), .rev_code(rev_code), .strap_a(strap_a),
        .strap_b(strap_b), .key_init(key_init), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [31:0] rev, logic [31:0] key);
        @(negedge clk);
        rst = 1'b1; rev_code = rev; key_init = key; bus_sel = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // One access; outputs are sampled one negedge after the request.
    task automatic access(logic wr, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 reset ready", {31'b0, bus_ready}, 32'h0);
        chk("R10 reset err",   {31'b0, bus_err},   32'h0);
        chk("R10 reset rdata", bus_rdata,          32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VECS[i].wr, VECS[i].addr, VECS[i].wdata);
            chk($sformatf("R%0d data @%h", VECS[i].req, VECS[i].addr), bus_rdata, VECS[i].exp_data);
            chk($sformatf("R%0d err @%h",  VECS[i].req, VECS[i].addr), {31'b0, bus_err}, {31'b0, VECS[i].exp_err});
            chk("R10 ready", {31'b0, bus_ready}, 32'h1);
        end

        // R11: the error pulse lasts one cycle; R10: ready drops when idle.
        access(1'b1, 12'h014, 32'h9);
        chk("R11 err pulse", {31'b0, bus_err}, 32'h1);
        @(negedge clk);
        chk("R11 err cleared", {31'b0, bus_err},   32'h0);
        chk("R10 idle ready",  {31'b0, bus_ready}, 32'h0);

        // R7: second image; R9: nonzero key_init leaves the bank unlocked.
        do_reset(REV_B0, 32'h0000_FFFF);
        access(1'b0, 12'h024, 32'h0); chk("R7 B 0x24", bus_rdata, 32'h9300_0400);
        access(1'b0, 12'h088, 32'h0); chk("R7 B 0x88", bus_rdata, 32'h0300_0000);
        access(1'b0, 12'h08C, 32'h0); chk("R7 B 0x8C", bus_rdata, 32'h0000_0000);
        access(1'b0, 12'h09C, 32'h0); chk("R7 B 0x9C", bus_rdata, 32'h023F_FFF3);
        access(1'b0, 12'h000, 32'h0); chk("R9 key_init", bus_rdata, 32'h0000_FFFF);
        access(1'b1, 12'h044, 32'h5A5A_0001); chk("R9 unlocked err", {31'b0, bus_err}, 32'h0);
        access(1'b0, 12'h044, 32'h0); chk("R9 unlocked write", bus_rdata, 32'h5A5A_0001);

        do_reset(REV_B1, 32'h0);
        access(1'b0, 12'h09C, 32'h0); chk("R7 B1 0x9C", bus_rdata, 32'h023F_FFF3);
        access(1'b0, 12'h044, 32'h0); chk("R8 reset clears 0x44", bus_rdata, 32'h0);

        // R7: unknown code falls back to the first image.
        do_reset(32'h1234_5678, 32'h0);
        access(1'b0, 12'h024, 32'h0); chk("R7 unknown 0x24", bus_rdata, 32'h0000_0291);
        access(1'b0, 12'h08C, 32'h0); chk("R7 unknown 0x8C", bus_rdata, 32'h0000_00FF);
        access(1'b0, 12'h07C, 32'h0); chk("R9 rev word",     bus_rdata, 32'h1234_5678);

        finish_run();
    end
endmodule